// File: doc/BRIEF.md
# Switch-Monitor Interrupt Generator

This block watches a bank of switch input levels and raises one shared interrupt request when something worth the host's attention has happened. Levels are sampled once per polling period while polling is switched on. The first sample after polling starts becomes the reference for later samples. After that, any enabled channel whose level differs from the previous sample is recorded. The block also records that initialization finished after a reset, that the first poll finished, and three fault events: temperature warning, over-voltage and parity failure.

The interrupt leaves the block as a pull-down enable for an active-low, open-drain line. The block only ever pulls the line low or lets go of it, so several blocks can share one line. A small register port sets the polling control, the period, the per-channel enables and the event enables. The same port reads one status word. Reading that word clears it, and any event that lands in the same cycle as the read is kept for the next read.

Top module: `switch_irq_gen`

## Requirements
- R1: `intPullEn` is 1 exactly when at least one status flag is latched. It falls in the cycle after a status read, unless a new event is latched in the cycle of that read.
- R2: After the hardware reset `rstN` is released, the POR flag (read bit 24) is set after INIT_CYCLES clock edges and `intPullEn` rises, even though every channel enable and event enable has reset to 0.
- R3: Writing 1 to bit 1 of the control register (address 0) acts as a full reset. The interrupt is released on the next cycle, every register returns to its reset value, and the POR sequence of R2 runs again.
- R4: While the polling control bit (bit 0 of address 0) is 0, no samples are taken. Input changes set no flag and do not move `intPullEn`.
- R5: The first poll after the polling control bit is set stores the sampled levels as the reference and sets the first-poll flag (read bit 25). It sets no change flag, even when inputs differ from earlier levels.
- R6: On each later poll, channel k counts as changed when its level differs from the previous poll. A change sets mask bit k and the change flag (read bit 26) only if bit k of the channel-enable register (address 2) is 1 and bit 0 of the event-enable register (address 3) is 1. The reference is updated on every poll, enabled or not.
- R7: A pulse on `faultTemp`, `faultOv` or `faultParity` sets read bit 27, 28 or 29 only when event-enable bit 1, 2 or 3 is set. Otherwise the line stays released.
- R8: A read of address 4 returns the changed-channel mask in bits 23:0 and the flags in bits 29:24, with bits 31:30 zero, on `regRdata` one cycle later. The read clears the flags and the mask. An event arriving in the same cycle is not in that word but appears in the next one.
- R9: A poll happens every PERIOD cycles, where PERIOD is the value at address 1 and 0 counts as 1. It resets to DEFAULT_PERIOD. The first poll completes PERIOD edges after the edge that writes the polling control bit.
- R10: Clearing the polling control bit makes the next poll after it is set again a new first poll, as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| swIn | input | N_CH | Switch input levels |
| faultTemp | input | 1 | Temperature warning event pulse |
| faultOv | input | 1 | Over-voltage event pulse |
| faultParity | input | 1 | Parity failure event pulse |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address (0 control, 1 period, 2 channel enables, 3 event enables, 4 status) |
| regWdata | input | N_CH | Register write data |
| regRdata | output | N_CH+8 | Status word captured by the last status read |
| intPullEn | output | 1 | 1 pulls the shared active-low interrupt line down |

## Verification
The checker checks every cycle that:
- a POR or first-poll event always leaves the line pulled on the next cycle;
- a soft reset always releases it;
- no poll occurs with polling off;
- a cycle with nothing enabled to latch never pulls a released line;
- a read with no new event releases the line.

Only the bench scenarios can show the rest:
- the exact values in the status word;
- the gating of each change by both the channel enable and the change-event enable;
- the reference moving on polls where nothing is enabled;
- the same-cycle read and event ordering;
- the poll timing for a programmed period, a period of 0 and the default period.

// File: rtl/swirq_pkg.sv
package swirq_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_CHEN   = 3'd2;
  localparam logic [ADDR_W-1:0] A_EVEN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;

  // event-enable bit positions
  localparam int EV_SSC  = 0;
  localparam int EV_TEMP = 1;
  localparam int EV_OV   = 2;
  localparam int EV_PAR  = 3;
  localparam int EV_W    = 4;

  localparam int STAT_W  = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic porSet;
    logic pollStrobe;
    logic pollIsFirst;
    logic readClr;
  } swirqStrb_t;

  // latched causes, LSB first: por, first, ssc, temp, ov, parity
  typedef struct packed {
    logic parity;
    logic ov;
    logic temp;
    logic ssc;
    logic first;
    logic por;
  } swirqStat_t;
endpackage

// File: rtl/swirq_ctrl.sv
module swirq_ctrl
  import swirq_pkg::*;
#(
  parameter int N_CH           = 24,
  parameter int PER_W          = 16,
  parameter int DEFAULT_PERIOD = 8,
  parameter int INIT_CYCLES    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [N_CH-1:0]   regWdata,
  output swirqStrb_t        strb,
  output logic              trigger,
  output logic [N_CH-1:0]   chEn,
  output logic [EV_W-1:0]   evEn
);
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);

  logic [PER_W-1:0]  period;
  logic [PER_W-1:0]  perEff;
  logic [PER_W-1:0]  pollCnt;
  logic [INIT_W-1:0] initCnt;
  logic              initDone;
  logic              firstPending;
  logic              swRstReq;
  logic              wrCtrl;
  logic              pollActive;
  logic              lastTick;

  assign wrCtrl     = regWr && (regAddr == A_CTRL);
  assign perEff     = (period == '0) ? PER_W'(1) : period;
  assign pollActive = trigger && initDone;
  assign lastTick   = pollCnt >= (perEff - PER_W'(1));

  always_comb begin
    strb.clearAll    = swRstReq;
    strb.porSet      = !initDone && (initCnt == INIT_W'(INIT_CYCLES - 1));
    strb.pollStrobe  = pollActive && lastTick;
    strb.pollIsFirst = firstPending;
    strb.readClr     = regRd && (regAddr == A_STAT);
  end

  // soft reset request, one cycle wide
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swRstReq <= 1'b0;
    else       swRstReq <= !swRstReq && wrCtrl && regWdata[1];
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigger <= 1'b0;
      period  <= PER_W'(DEFAULT_PERIOD);
      chEn    <= '0;
      evEn    <= '0;
    end else if (swRstReq) begin
      trigger <= 1'b0;
      period  <= PER_W'(DEFAULT_PERIOD);
      chEn    <= '0;
      evEn    <= '0;
    end else if (regWr) begin
      case (regAddr)
        A_CTRL:   trigger <= regWdata[0];
        A_PERIOD: period  <= regWdata[PER_W-1:0];
        A_CHEN:   chEn    <= regWdata;
        A_EVEN:   evEn    <= regWdata[EV_W-1:0];
        default:  ;
      endcase
    end
  end

  // initialization sequence after any reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt  <= '0;
      initDone <= 1'b0;
    end else if (swRstReq) begin
      initCnt  <= '0;
      initDone <= 1'b0;
    end else if (!initDone) begin
      initCnt <= initCnt + INIT_W'(1);
      if (initCnt == INIT_W'(INIT_CYCLES - 1)) initDone <= 1'b1;
    end
  end

  // polling timer and first-cycle marker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt      <= '0;
      firstPending <= 1'b1;
    end else if (swRstReq) begin
      pollCnt      <= '0;
      firstPending <= 1'b1;
    end else begin
      if (!pollActive)   pollCnt <= '0;
      else if (lastTick) pollCnt <= '0;
      else               pollCnt <= pollCnt + PER_W'(1);

      if (!trigger)              firstPending <= 1'b1;
      else if (strb.pollStrobe)  firstPending <= 1'b0;
    end
  end
endmodule

// File: rtl/swirq_dp.sv
module swirq_dp
  import swirq_pkg::*;
#(
  parameter int N_CH = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  swirqStrb_t      strb,
  input  logic [N_CH-1:0] swIn,
  input  logic [N_CH-1:0] chEn,
  input  logic [EV_W-1:0] evEn,
  input  logic            faultTemp,
  input  logic            faultOv,
  input  logic            faultParity,
  output logic            intPullEn,
  output logic [N_CH+7:0] regRdata
);
  localparam int RD_W = N_CH + 8;

  logic [N_CH-1:0] baseline;
  logic [N_CH-1:0] chgMask;
  logic [N_CH-1:0] hit;
  logic [N_CH-1:0] newMask;
  swirqStat_t      stat;
  swirqStat_t      setStat;
  logic [RD_W-1:0] word;

  // per-channel change detection against the reference
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign hit[c] = (swIn[c] ^ baseline[c]) & chEn[c];
  end

  assign newMask = (strb.pollStrobe && !strb.pollIsFirst && evEn[EV_SSC]) ? hit : '0;

  always_comb begin
    setStat.por    = strb.porSet;
    setStat.first  = strb.pollStrobe && strb.pollIsFirst;
    setStat.ssc    = |newMask;
    setStat.temp   = faultTemp && evEn[EV_TEMP];
    setStat.ov     = faultOv && evEn[EV_OV];
    setStat.parity = faultParity && evEn[EV_PAR];
  end

  always_comb begin
    word                   = '0;
    word[N_CH-1:0]         = chgMask;
    word[N_CH +: STAT_W]   = stat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseline <= '0;
      chgMask  <= '0;
      stat     <= '0;
      regRdata <= '0;
    end else if (strb.clearAll) begin
      baseline <= '0;
      chgMask  <= '0;
      stat     <= '0;
      regRdata <= '0;
    end else begin
      if (strb.pollStrobe) baseline <= swIn;
      if (strb.readClr) begin
        regRdata <= word;
        stat     <= setStat;
        chgMask  <= newMask;
      end else begin
        stat     <= swirqStat_t'(stat | setStat);
        chgMask  <= chgMask | newMask;
      end
    end
  end

  assign intPullEn = |stat;
endmodule

// File: rtl/switch_irq_gen.sv
module switch_irq_gen
  import swirq_pkg::*;
#(
  parameter int N_CH           = 24,
  parameter int PER_W          = 16,
  parameter int DEFAULT_PERIOD = 8,
  parameter int INIT_CYCLES    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_CH-1:0]   swIn,
  input  logic              faultTemp,
  input  logic              faultOv,
  input  logic              faultParity,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [N_CH-1:0]   regWdata,
  output logic [N_CH+7:0]   regRdata,
  output logic              intPullEn
);
  swirqStrb_t      strb;
  logic            trigger;
  logic [N_CH-1:0] chEn;
  logic [EV_W-1:0] evEn;

  swirq_ctrl #(
    .N_CH(N_CH), .PER_W(PER_W),
    .DEFAULT_PERIOD(DEFAULT_PERIOD), .INIT_CYCLES(INIT_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .strb(strb), .trigger(trigger), .chEn(chEn), .evEn(evEn)
  );

  swirq_dp #(.N_CH(N_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .swIn(swIn), .chEn(chEn), .evEn(evEn),
    .faultTemp(faultTemp), .faultOv(faultOv), .faultParity(faultParity),
    .intPullEn(intPullEn), .regRdata(regRdata)
  );
endmodule

// File: rtl/swirq_chk.sv
module swirq_chk
  import swirq_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input swirqStrb_t strb,
  input logic       trigger,
  input logic [3:1] faultEn,
  input logic       faultTemp,
  input logic       faultOv,
  input logic       faultParity,
  input logic       intPullEn
);
  logic faultSet;
  assign faultSet = (faultTemp && faultEn[1]) || (faultOv && faultEn[2]) ||
                    (faultParity && faultEn[3]);

  // R2: completed initialization always pulls the line
  a_r2_por_pulls: assert property (@(posedge clk) disable iff (!rstN)
    strb.porSet && !strb.clearAll |=> intPullEn);

  // R5: completed first poll always pulls the line
  a_r5_first_pulls: assert property (@(posedge clk) disable iff (!rstN)
    strb.pollStrobe && strb.pollIsFirst && !strb.clearAll |=> intPullEn);

  // R4: no sampling with polling off
  a_r4_no_poll_idle: assert property (@(posedge clk) disable iff (!rstN)
    !trigger |-> !strb.pollStrobe);

  // R3: soft reset releases the line
  a_r3_softrst_release: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> !intPullEn);

  // R7: with nothing enabled to latch, a released line stays released
  a_r7_quiet_released: assert property (@(posedge clk) disable iff (!rstN)
    !intPullEn && !strb.porSet && !strb.pollStrobe && !faultSet |=> !intPullEn);

  // R8: a read with no concurrent event releases the line
  a_r8_read_release: assert property (@(posedge clk) disable iff (!rstN)
    strb.readClr && !strb.porSet && !strb.pollStrobe && !faultSet |=> !intPullEn);
endmodule

bind switch_irq_gen swirq_chk u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .trigger(trigger),
  .faultEn(evEn[3:1]), .faultTemp(faultTemp), .faultOv(faultOv),
  .faultParity(faultParity), .intPullEn(intPullEn)
);

// File: tb/switch_irq_gen_tb.sv
module switch_irq_gen_tb;
  localparam int N_CH = 24;
  localparam int INIT = 4;
  localparam int DEFP = 8;

  logic            clk = 1'b0;
  logic            rstN;
  logic [N_CH-1:0] swIn;
  logic            faultTemp, faultOv, faultParity;
  logic            regWr, regRd;
  logic [2:0]      regAddr;
  logic [N_CH-1:0] regWdata;
  logic [31:0]     regRdata;
  logic            intPullEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  switch_irq_gen #(.N_CH(N_CH), .DEFAULT_PERIOD(DEFP), .INIT_CYCLES(INIT)) u_dut (
    .clk(clk), .rstN(rstN), .swIn(swIn),
    .faultTemp(faultTemp), .faultOv(faultOv), .faultParity(faultParity),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .intPullEn(intPullEn)
  );

  function automatic logic [31:0] statWord(input logic [5:0] flags, input logic [23:0] mask);
    return {2'b00, flags, mask};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N_CH-1:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = 3'd4;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countToPull(output int k);
    k = 0;
    while (!intPullEn && k < 100) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [31:0] d;
    logic [23:0] base, expMask, chEnM, prev;
    logic        sscOn;
    int k;

    void'($urandom(32'h5eed));
    rstN = 1'b0; swIn = '0; faultTemp = 0; faultOv = 0; faultParity = 0;
    regWr = 0; regRd = 0; regAddr = '0; regWdata = '0;
    waitCyc(3);
    chk("R1 released in reset", {31'd0, intPullEn}, 32'd0);
    rstN = 1'b1;

    // R2: POR flag after exactly INIT edges
    waitCyc(INIT - 1);
    chk("R2 not before init", {31'd0, intPullEn}, 32'd0);
    waitCyc(1);
    chk("R2 pull after init", {31'd0, intPullEn}, 32'd1);
    rd(d);
    chk("R2 R8 por word", d, statWord(6'b000001, '0));
    chk("R1 released after read", {31'd0, intPullEn}, 32'd0);

    // R4: polling off, inputs ignored
    wr(3'd1, 24'd4);
    wr(3'd2, '1);
    wr(3'd3, 24'd1);
    for (int i = 0; i < 5; i++) begin
      swIn = 24'($urandom);
      waitCyc(10);
    end
    chk("R4 idle no pull", {31'd0, intPullEn}, 32'd0);
    rd(d);
    chk("R4 idle no flags", d, 32'd0);

    // R5 R9: first poll timing and baseline capture
    swIn = 24'($urandom) | 24'h1;
    wr(3'd0, 24'd1);
    countToPull(k);
    chk("R9 first poll after period 4", k, 4);
    rd(d);
    chk("R5 first-poll word", d, statWord(6'b000010, '0));
    base = swIn; expMask = '0; chEnM = '1; sscOn = 1'b1;

    // R6: random rounds
    for (int r = 0; r < 80; r++) begin
      if ($urandom % 4 != 0) swIn = 24'($urandom);
      waitCyc(10);
      if (sscOn) expMask = expMask | ((swIn ^ base) & chEnM);
      base = swIn;
      chk("R1 R6 pull tracks changes", {31'd0, intPullEn}, {31'd0, expMask != 0});
      if (r % 5 == 4) begin
        rd(d);
        chk("R6 R8 change word", d, statWord({3'b000, expMask != 0, 2'b00}, expMask));
        expMask = '0;
        chEnM = 24'($urandom);
        sscOn = ($urandom % 4) != 0;
        wr(3'd2, chEnM);
        wr(3'd3, {23'd0, sscOn});
      end
    end
    rd(d);
    chk("R6 R8 final change word", d, statWord({3'b000, expMask != 0, 2'b00}, expMask));

    // R7: fault gating
    wr(3'd3, 24'd0);
    @(negedge clk); faultTemp = 1; faultOv = 1; faultParity = 1;
    @(negedge clk); faultTemp = 0; faultOv = 0; faultParity = 0;
    waitCyc(2);
    chk("R7 faults disabled no pull", {31'd0, intPullEn}, 32'd0);
    wr(3'd3, 24'b0100);
    @(negedge clk); faultTemp = 1;
    @(negedge clk); faultTemp = 0;
    chk("R7 temp masked", {31'd0, intPullEn}, 32'd0);
    @(negedge clk); faultOv = 1;
    @(negedge clk); faultOv = 0;
    chk("R7 ov pulls", {31'd0, intPullEn}, 32'd1);
    @(negedge clk); faultParity = 1;
    @(negedge clk); faultParity = 0;
    rd(d);
    chk("R7 ov only word", d, statWord(6'b010000, '0));

    // R8: event in the cycle of a read is kept
    wr(3'd3, 24'b1000);
    @(negedge clk); regRd = 1; regAddr = 3'd4; faultParity = 1;
    @(negedge clk); regRd = 0; faultParity = 0;
    chk("R8 same-cycle event not in word", regRdata, 32'd0);
    chk("R8 same-cycle event holds pull", {31'd0, intPullEn}, 32'd1);
    rd(d);
    chk("R8 event in next word", d, statWord(6'b100000, '0));
    chk("R1 R8 released", {31'd0, intPullEn}, 32'd0);

    // R10: re-arm gives a new first poll; period 0 acts as 1
    wr(3'd0, 24'd0);
    wr(3'd2, '1);
    wr(3'd3, 24'd1);
    swIn = ~swIn;
    waitCyc(20);
    chk("R4 stopped no pull", {31'd0, intPullEn}, 32'd0);
    wr(3'd1, 24'd0);
    wr(3'd0, 24'd1);
    countToPull(k);
    chk("R9 period zero acts as one", k, 1);
    rd(d);
    chk("R10 new first poll no change", d, statWord(6'b000010, '0));
    prev = swIn;
    swIn = prev ^ 24'h000800;
    waitCyc(6);
    rd(d);
    chk("R6 single channel change", d, statWord(6'b000100, 24'h000800));

    // R3: soft reset
    wr(3'd3, 24'hF);
    wr(3'd0, 24'd3);
    @(negedge clk);
    chk("R3 released after soft reset", {31'd0, intPullEn}, 32'd0);
    waitCyc(INIT - 1);
    chk("R3 por not early", {31'd0, intPullEn}, 32'd0);
    waitCyc(1);
    chk("R3 por rerun", {31'd0, intPullEn}, 32'd1);
    rd(d);
    chk("R3 por word", d, statWord(6'b000001, '0));
    swIn = ~swIn;
    @(negedge clk); faultTemp = 1;
    @(negedge clk); faultTemp = 0;
    waitCyc(30);
    chk("R3 trigger and enables cleared", {31'd0, intPullEn}, 32'd0);
    wr(3'd0, 24'd1);
    countToPull(k);
    chk("R9 R3 default period", k, DEFP);
    rd(d);
    chk("R3 R5 first poll after reset", d, statWord(6'b000010, '0));

    done = 1;
    finishRun();
  end
endmodule